// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

The sequencer keeps an SDRAM-style mode word and, for each read or write command, produces the column addresses of the burst, one per clock. The mode word sets the burst length (1, 2, 4, 8 or a full page), the order of the beats (sequential or interleaved), the CAS latency and whether writes are single-location accesses. A controller loads the mode word once after power-up. It then issues commands carrying a starting column and follows `col_o` while `col_valid_o` is high.

A fixed-length burst stays inside an aligned group of BL columns. The upper column bits pick the group, and the low bits give the first beat and wrap at the group edge. A full-page burst steps through all 256 columns from any start. It keeps running until a terminate strobe or a new command arrives. When a mode word holds a reserved code, the block raises an error flag and keeps its previous settings.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_valid_o`, `last_o` and `mode_err_o` are 0, `cas_lat_o` is 2, and the active mode is burst length 1, sequential, writes at programmed length.
- R2: Mode field [2:0] sets the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page. A fixed-length burst gives exactly BL valid beats. `last_o` is high on the final beat only, and `col_valid_o` drops on the next clock.
- R3: Mode bit [3]=0 selects sequential order. Beat k is the start column with its low log2(BL) bits replaced by (low start bits + k) mod BL, so the burst wraps inside the aligned group.
- R4: Mode bit [3]=1 selects interleaved order. Beat k is the start column with its low log2(BL) bits replaced by (low start bits XOR k).
- R5: A full-page burst visits column (start + k) mod 256 on beat k. It continues past 256 beats, never raises `last_o`, and stops only on terminate or a new command.
- R6: `term_i` high with no command clears `col_valid_o` on the next clock. When the block is idle it has no effect.
- R7: A command is sampled on a rising edge. The next cycle shows its start column with `col_valid_o` high, and a command during an active burst aborts that burst.
- R8: Mode bit [9]=1 turns every write (`cmd_write_i`=1) into a single beat with `last_o` set. Reads keep the programmed length.
- R9: Mode field [6:4] holds the CAS latency: 010 gives `cas_lat_o`=2 and 011 gives 3. `cas_lat_o` changes only on a mode load.
- R10: A mode word is rejected if its length code is 100, 101 or 110, its latency code is not 010 or 011, bits [8:7] or [11:10] are nonzero, or it combines interleaved order with full page. A rejected word sets `mode_err_o` and leaves all settings unchanged. An accepted word clears `mode_err_o`.
- R11: A command uses the mode in force before the edge that samples it, including when a mode load arrives on the same edge. A mode load does not alter a burst already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Load strobe for the mode word |
| mode_word_i | input | 12 | Mode word |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_col_i | input | 8 | Starting column |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | 8 | Current column of the burst |
| col_valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cas_lat_o | output | 2 | Decoded CAS latency |
| mode_err_o | output | 1 | Last mode word was rejected |

## Verification
The assertions check the handshake timing on every cycle: a command shows its start column on the following cycle, `last_o` and terminate end the burst one clock later, an unfinished burst keeps going, and the latency and error outputs move only on a mode load. The beat order itself can only be shown by the bench's reference model. That covers wrap points in sequential and interleaved groups, the full-page wrap past 256 beats, single-beat writes, and rejected words leaving the old mode in force. The model is compared against every output on every clock across those scenarios.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} burst_ord_e;

  // Field layout fixed by the mode word format
  typedef struct packed {
    logic [1:0] rsv;
    logic       wb_single;
    logic [1:0] op;
    logic [2:0] cl;
    logic       ilv;
    logic [2:0] bl;
  } mode_word_t;

  localparam int unsigned MODE_W = $bits(mode_word_t);

  localparam logic [2:0] BL_1    = 3'b000;
  localparam logic [2:0] BL_2    = 3'b001;
  localparam logic [2:0] BL_4    = 3'b010;
  localparam logic [2:0] BL_8    = 3'b011;
  localparam logic [2:0] BL_PAGE = 3'b111;
  localparam logic [2:0] CL_2    = 3'b010;
  localparam logic [2:0] CL_3    = 3'b011;
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  mode_word_t       word_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output burst_ord_e       ord_o,
  output logic [1:0]       cas_o,
  output logic             wb_single_o,
  output logic             err_o
);
  logic             bl_ok, cl_ok, word_ok, new_full;
  logic [COL_W-1:0] new_mask;

  always_comb begin
    bl_ok    = 1'b1;
    new_full = 1'b0;
    case (word_i.bl)
      BL_1:    new_mask = '0;
      BL_2:    new_mask = COL_W'(1);
      BL_4:    new_mask = COL_W'(3);
      BL_8:    new_mask = COL_W'(7);
      BL_PAGE: begin new_mask = '1; new_full = 1'b1; end
      default: begin new_mask = '0; bl_ok = 1'b0; end
    endcase
    cl_ok   = (word_i.cl == CL_2) || (word_i.cl == CL_3);
    word_ok = bl_ok && cl_ok && (word_i.op == 2'b00) && (word_i.rsv == 2'b00)
              && !(new_full && word_i.ilv);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o      <= '0;
      full_o      <= 1'b0;
      ord_o       <= ORD_SEQ;
      cas_o       <= 2'd2;
      wb_single_o <= 1'b0;
      err_o       <= 1'b0;
    end else if (load_i) begin
      err_o <= !word_ok;
      if (word_ok) begin
        mask_o      <= new_mask;
        full_o      <= new_full;
        ord_o       <= burst_ord_e'(word_i.ilv);
        cas_o       <= {1'b1, word_i.cl[0]};
        wb_single_o <= word_i.wb_single;
      end
    end
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  burst_ord_e       ord_i,
  input  logic             wb_single_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] start_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output burst_ord_e       ord_o
);
  logic full_q;

  assign last_o = active_o && !full_q && (cnt_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      start_o  <= '0;
      mask_o   <= '0;
      full_q   <= 1'b0;
      ord_o    <= ORD_SEQ;
    end else if (cmd_i) begin
      active_o <= 1'b1;
      cnt_o    <= '0;
      start_o  <= col_i;
      ord_o    <= ord_i;
      // single-location write overrides the programmed length
      if (wr_i && wb_single_i) begin
        mask_o <= '0;
        full_q <= 1'b0;
      end else begin
        mask_o <= mask_i;
        full_q <= full_i;
      end
    end else if (term_i) begin
      active_o <= 1'b0;
    end else if (active_o) begin
      if (last_o) active_o <= 1'b0;
      else        cnt_o    <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_ord_e       ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] ofs;

  assign ofs = (ord_i == ORD_ILV) ? (start_i ^ cnt_i) : (start_i + cnt_i);

  // bits inside the group move, bits above it stay with the start column
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? ofs[i] : start_i[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              cmd_valid_i,
  input  logic              cmd_write_i,
  input  logic [COL_W-1:0]  cmd_col_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              last_o,
  output logic [1:0]        cas_lat_o,
  output logic              mode_err_o
);
  logic [COL_W-1:0] m_mask, b_start, b_cnt, b_mask;
  logic             m_full, m_wb;
  burst_ord_e       m_ord, b_ord;

  bcs_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (mode_load_i),
    .word_i      (mode_word_t'(mode_word_i)),
    .mask_o      (m_mask),
    .full_o      (m_full),
    .ord_o       (m_ord),
    .cas_o       (cas_lat_o),
    .wb_single_o (m_wb),
    .err_o       (mode_err_o)
  );

  bcs_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_valid_i),
    .wr_i        (cmd_write_i),
    .col_i       (cmd_col_i),
    .term_i      (term_i),
    .mask_i      (m_mask),
    .full_i      (m_full),
    .ord_i       (m_ord),
    .wb_single_i (m_wb),
    .active_o    (col_valid_o),
    .last_o      (last_o),
    .start_o     (b_start),
    .cnt_o       (b_cnt),
    .mask_o      (b_mask),
    .ord_o       (b_ord)
  );

  bcs_col_gen #(.COL_W(COL_W)) u_col (
    .start_i (b_start),
    .cnt_i   (b_cnt),
    .mask_i  (b_mask),
    .ord_i   (b_ord),
    .col_o   (col_o)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_load_i,
  input logic             cmd_valid_i,
  input logic [COL_W-1:0] cmd_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             col_valid_o,
  input logic             last_o,
  input logic [1:0]       cas_lat_o,
  input logic             mode_err_o
);
  assert_cmd_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> col_valid_o && (col_o == $past(cmd_col_i)));

  assert_last_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> col_valid_o);

  assert_last_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !cmd_valid_i |=> !col_valid_o);

  assert_term_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i && !cmd_valid_i |=> !col_valid_o);

  assert_burst_runs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_valid_o && !last_o && !cmd_valid_i && !term_i |=> col_valid_o);

  assert_cas_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_lat_o == 2'd2) || (cas_lat_o == 2'd3));

  assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_load_i |=> $stable(cas_lat_o) && $stable(mode_err_o));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_load_i (mode_load_i),
  .cmd_valid_i (cmd_valid_i),
  .cmd_col_i   (cmd_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .col_valid_o (col_valid_o),
  .last_o      (last_o),
  .cas_lat_o   (cas_lat_o),
  .mode_err_o  (mode_err_o)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic        cmd_v = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  cmd_col = '0;
  logic        term = 1'b0;
  logic [7:0]  col;
  logic        col_valid, last;
  logic [1:0]  cas;
  logic        merr;

  int    nchk = 0;
  int    nerr = 0;
  int    cycles = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  burst_col_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(mode_load), .mode_word_i(mode_word),
    .cmd_valid_i(cmd_v), .cmd_write_i(cmd_wr), .cmd_col_i(cmd_col), .term_i(term),
    .col_o(col), .col_valid_o(col_valid), .last_o(last), .cas_lat_o(cas),
    .mode_err_o(merr)
  );

  // reference model: mode settings
  int md_len, md_cas;   // md_len 0 means full page
  bit md_ilv, md_wb, md_err;
  // reference model: burst in flight
  bit b_act, b_ilv, b_full;
  int b_start, b_cnt, b_len;

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_col();
    int lo, blk;
    if (b_full) return (b_start + b_cnt) % 256;
    lo  = b_start % b_len;
    blk = b_start - lo;
    if (b_ilv) return blk + (lo ^ b_cnt);
    return blk + ((lo + b_cnt) % b_len);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md_len = 1; md_cas = 2; md_ilv = 0; md_wb = 0; md_err = 0;
      b_act = 0; b_ilv = 0; b_full = 0; b_start = 0; b_cnt = 0; b_len = 1;
    end else begin
      if (cmd_v) begin
        b_act = 1; b_cnt = 0; b_start = int'(cmd_col); b_ilv = md_ilv;
        if (cmd_wr && md_wb) begin b_len = 1; b_full = 0; end
        else if (md_len == 0) begin b_len = 256; b_full = 1; end
        else begin b_len = md_len; b_full = 0; end
      end else if (term) begin
        b_act = 0;
      end else if (b_act) begin
        if (!b_full && b_cnt == b_len - 1) b_act = 0;
        else b_cnt = b_cnt + 1;
      end
      if (mode_load) begin
        int l, c;
        bit ok;
        l  = len_of(int'(mode_word[2:0]));
        c  = int'(mode_word[6:4]);
        ok = (l >= 0) && (c == 2 || c == 3) && (mode_word[8:7] == 0) &&
             (mode_word[11:10] == 0) && !(l == 0 && mode_word[3]);
        md_err = !ok;
        if (ok) begin
          md_len = l; md_cas = c; md_ilv = mode_word[3]; md_wb = mode_word[9];
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare against the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(cur_req, "col_valid", int'(col_valid), int'(b_act));
      if (b_act) begin
        chk(cur_req, "col", int'(col), exp_col());
        chk(cur_req, "last", int'(last), int'(!b_full && b_cnt == b_len - 1));
      end else begin
        chk(cur_req, "last", int'(last), 0);
      end
      chk(cur_req, "cas", int'(cas), md_cas);
      chk(cur_req, "mode_err", int'(merr), int'(md_err));
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [11:0] w);
    mode_load = 1'b1; mode_word = w;
    tick(1);
    mode_load = 1'b0;
  endtask

  task automatic issue(logic wr, logic [7:0] c);
    cmd_v = 1'b1; cmd_wr = wr; cmd_col = c;
    tick(1);
    cmd_v = 1'b0;
  endtask

  task automatic stop();
    term = 1'b1;
    tick(1);
    term = 1'b0;
  endtask

  initial begin
    #35 rst_n = 1'b1;
    tick(1);
    // R1: reset values at the ports
    chk("R1", "reset col_valid", int'(col_valid), 0);
    chk("R1", "reset last", int'(last), 0);
    chk("R1", "reset cas", int'(cas), 2);
    chk("R1", "reset mode_err", int'(merr), 0);
    cur_req = "R1"; issue(1'b0, 8'h33); tick(3);

    // R2 R3 R9: lengths 2/4/8 sequential, CAS 3 then 2
    cur_req = "R9"; load(12'h031); tick(1);
    cur_req = "R2"; issue(1'b0, 8'h45); tick(4);
    cur_req = "R3"; load(12'h032); issue(1'b0, 8'h46); tick(6);
    load(12'h023); issue(1'b0, 8'h5D); tick(10);
    issue(1'b1, 8'hF8); tick(10);
    cur_req = "R9"; load(12'h020); issue(1'b0, 8'h07); tick(3);

    // R4: interleaved orders
    cur_req = "R4"; load(12'h02B); issue(1'b0, 8'h5D); tick(10);
    load(12'h02A); issue(1'b0, 8'h92); tick(6);
    load(12'h029); issue(1'b1, 8'h11); tick(4);

    // R5: full page, past the wrap, then terminate
    cur_req = "R5"; load(12'h027); issue(1'b0, 8'hF0); tick(300);
    cur_req = "R6"; stop(); tick(3);
    stop(); tick(2);

    // R6: terminate a fixed burst midway
    load(12'h023); issue(1'b0, 8'h20); tick(3); stop(); tick(4);

    // R7: new command aborts running bursts
    cur_req = "R7"; issue(1'b0, 8'h40); tick(2); issue(1'b0, 8'h83); tick(10);
    issue(1'b0, 8'h10); issue(1'b0, 8'hC5); tick(10);
    cmd_v = 1'b1; cmd_col = 8'h66; term = 1'b1; tick(1); cmd_v = 1'b0; term = 1'b0; tick(10);

    // R8: writes become single beats, reads keep length
    cur_req = "R8"; load(12'h223); issue(1'b1, 8'h34); tick(3);
    issue(1'b0, 8'h34); tick(10);
    load(12'h227); issue(1'b1, 8'hAA); tick(3);
    issue(1'b0, 8'hFE); tick(5); stop(); tick(2);

    // R10: rejected words keep the old mode (BL8 seq CL2)
    cur_req = "R10"; load(12'h023);
    load(12'h024); issue(1'b0, 8'h0B); tick(9);
    load(12'h013); issue(1'b0, 8'h0B); tick(9);
    load(12'h0A3); load(12'h123); load(12'h423); load(12'h823);
    load(12'h02F); load(12'h025); load(12'h043);
    issue(1'b1, 8'h0B); tick(9);
    load(12'h031); tick(1);
    issue(1'b0, 8'h0B); tick(3);

    // R11: mode change alongside or during a burst
    cur_req = "R11"; load(12'h023); tick(1);
    mode_load = 1'b1; mode_word = 12'h029; cmd_v = 1'b1; cmd_wr = 1'b0; cmd_col = 8'h57;
    tick(1); mode_load = 1'b0; cmd_v = 1'b0;
    tick(1); load(12'h030); tick(8);
    issue(1'b0, 8'h57); tick(3);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule